// File: doc/BRIEF.md
# ROM Search Pass Sequencer for a Single-Wire Bus

This block runs one pass of the binary-tree search that finds the 64-bit identifiers of all devices on a shared open-drain single-wire bus. It does not drive the wire itself. Instead it asks a separate slot engine for three kinds of operation: a bus reset with presence sampling, a byte write, and a single read/write bit slot. It waits for the engine to finish each operation before it asks for the next one.

Before a pass, the caller loads the identifier found by the previous pass. It also presents the discrepancy position that the previous pass returned. The block then resets the bus and sends the search command. For each of the 64 bit positions it reads the bit, reads the complement of the bit, and picks a branch. It writes the chosen branch back to the bus and stores it in the identifier register. The pass returns either the next discrepancy position or an error code.

To enumerate every device, the caller starts with a discrepancy above 64. It then feeds each result and identifier back into the next pass until the result is 0.

Top module: `ow_rom_search`

## Requirements
- R1: On `start` in idle, the first operation requested is a bus reset (`op_kind`=0). If the engine answers with `op_rbit`=0 (no presence), the pass ends with `result`=0xFF and no further operation is requested.
- R2: After a presence answer, the block requests one byte write (`op_kind`=2) with `op_data`=0xF0. It then requests exactly three bit slots (`op_kind`=1, written value in `op_data[0]`) per position. The first two slots write 1 and read the bit and its complement. The third slot writes the chosen direction. A complete pass uses 1 reset, 1 byte and 192 bit slots.
- R3: If both the bit and its complement read as 1, the pass ends with `result`=0xFE, and no write slot is issued for that position.
- R4: If the bit and its complement differ, the direction written and stored is the bit that was read.
- R5: Positions are indexed 64 for identifier bit 0 down to 1 for identifier bit 63. If both reads are 0, direction 1 is taken when the previous discrepancy is greater than the index. It is also taken when the loaded identifier bit at this position is 1 and the index differs from the previous discrepancy. Otherwise direction 0 is taken. A previous discrepancy above 64 therefore starts a fresh search.
- R6: The returned discrepancy is the index of the last position, in transfer order, where direction 1 was taken at a conflict. It is 0 when no such position exists, which marks the last device.
- R7: The direction chosen at the k-th transferred position is written to `id_out[k]`. Byte n of the identifier is therefore `id_out[8n+7:8n]`, received least significant bit first.
- R8: `id_load` in idle copies `id_in` into `id_out` on the next clock edge.
- R9: `done` is a one-cycle pulse, and `result` holds its value until the next pass ends. `start` while `busy` is ignored: it requests no new reset and leaves the running pass unchanged, including its captured previous discrepancy.
- R10: Once `op_req` is raised, it stays high with `op_kind` and `op_data` unchanged until `op_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (idle only) |
| prev_disc | input | 8 | Discrepancy returned by the previous pass; above 64 for a fresh search |
| id_load | input | 1 | Load `id_in` into the identifier register (idle only) |
| id_in | input | 64 | Identifier from the previous pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| result | output | 8 | Next discrepancy (0..64), 0xFE data error, 0xFF no presence |
| id_out | output | 64 | Identifier register |
| op_req | output | 1 | Operation request to the slot engine |
| op_kind | output | 2 | 0 reset, 1 bit slot, 2 byte write |
| op_data | output | 8 | Byte to write, or bit to write in bit 0 |
| op_done | input | 1 | Engine completion pulse |
| op_rbit | input | 1 | Presence (reset) or sampled bus bit (bit slot) |

## Verification
The assertions assume three things about the slot engine. It pulses `op_done` for one cycle only while `op_req` is high. It answers each request exactly once. It never pulses `op_done` while the block is idle. They also assume that `id_load` is not asserted during a pass.

The bench engine is a wired-AND model of a set of devices. It waits a random latency of zero to two cycles, then answers each request at a falling edge. It always answers the request it saw. The bench drives `id_load` only between passes.

// File: rtl/ow_srch_pkg.sv
package ow_srch_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_BIT   = 2'd1,
    OP_BYTE  = 2'd2
  } op_kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_CMD,
    S_RD,
    S_RDC,
    S_WR
  } srch_st_t;

  localparam logic [7:0] SEARCH_CMD   = 8'hF0;
  localparam logic [7:0] LAST_DEVICE  = 8'h00;
  localparam logic [7:0] ERR_PRESENCE = 8'hFF;
  localparam logic [7:0] ERR_DATA     = 8'hFE;
endpackage

// File: rtl/ow_srch_pick.sv
module ow_srch_pick #(
  parameter int IDX_W = 7
) (
  input  logic             rd_bit,
  input  logic             rd_cmp,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       prev,
  input  logic             old_bit,
  output logic             dir,
  output logic             conflict,
  output logic             fault
);
  logic prev_above;
  logic prev_equal;

  always_comb begin
    prev_above = prev > 8'(idx);
    prev_equal = prev == 8'(idx);
    conflict   = !rd_bit && !rd_cmp;
    fault      = rd_bit && rd_cmp;
    if (conflict) dir = prev_above || (old_bit && !prev_equal);
    else          dir = rd_bit;
  end
endmodule

// File: rtl/ow_srch_idreg.sv
module ow_srch_idreg #(
  parameter int ID_W  = 64,
  parameter int POS_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ID_W-1:0]  load_val,
  input  logic             wr,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             wr_bit,
  output logic [ID_W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (wr)   q[wr_pos] <= wr_bit;
  end

  // R7: a write slot's direction lands at its position and nowhere else
  p_bit_stored_r7: assert property (@(posedge clk) disable iff (rst)
    wr && !load |=> q[$past(wr_pos)] == $past(wr_bit));
  p_one_bit_changed_r7: assert property (@(posedge clk) disable iff (rst)
    wr && !load |=> $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/ow_srch_seq.sv
module ow_srch_seq
  import ow_srch_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int IDX_W = $clog2(ID_W + 1),
  parameter int POS_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       prev_disc,
  output logic             busy,
  output logic             done,
  output logic [7:0]       result,
  output logic             op_req,
  output logic [1:0]       op_kind,
  output logic [7:0]       op_data,
  input  logic             op_done,
  input  logic             op_rbit,
  input  logic             old_bit,
  output logic             id_wr,
  output logic [POS_W-1:0] id_pos,
  output logic             id_bit
);
  srch_st_t         st;
  logic [IDX_W-1:0] idx;
  logic [7:0]       disc;
  logic [7:0]       prev_q;
  logic             rd_q;
  logic             dir, conflict, fault;

  ow_srch_pick #(.IDX_W(IDX_W)) u_pick (
    .rd_bit  (rd_q),
    .rd_cmp  (op_rbit),
    .idx     (idx),
    .prev    (prev_q),
    .old_bit (old_bit),
    .dir     (dir),
    .conflict(conflict),
    .fault   (fault)
  );

  assign busy   = st != S_IDLE;
  assign id_pos = POS_W'(ID_W - int'(idx));
  assign id_bit = dir;
  assign id_wr  = (st == S_RDC) && op_done && !fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      op_req  <= 1'b0;
      op_kind <= OP_RESET;
      op_data <= '0;
      idx     <= IDX_W'(ID_W);
      disc    <= LAST_DEVICE;
      prev_q  <= '0;
      rd_q    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          prev_q  <= prev_disc;
          disc    <= LAST_DEVICE;
          idx     <= IDX_W'(ID_W);
          op_req  <= 1'b1;
          op_kind <= OP_RESET;
          op_data <= '0;
          st      <= S_RST;
        end
        S_RST: if (op_done) begin
          if (!op_rbit) begin
            op_req <= 1'b0;
            done   <= 1'b1;
            result <= ERR_PRESENCE;
            st     <= S_IDLE;
          end else begin
            op_kind <= OP_BYTE;
            op_data <= SEARCH_CMD;
            st      <= S_CMD;
          end
        end
        S_CMD: if (op_done) begin
          op_kind <= OP_BIT;
          op_data <= 8'h01;
          st      <= S_RD;
        end
        S_RD: if (op_done) begin
          rd_q    <= op_rbit;
          op_kind <= OP_BIT;
          op_data <= 8'h01;
          st      <= S_RDC;
        end
        S_RDC: if (op_done) begin
          if (fault) begin
            op_req <= 1'b0;
            done   <= 1'b1;
            result <= ERR_DATA;
            st     <= S_IDLE;
          end else begin
            if (conflict && dir) disc <= 8'(idx);
            op_kind <= OP_BIT;
            op_data <= {7'd0, dir};
            st      <= S_WR;
          end
        end
        S_WR: if (op_done) begin
          if (idx == IDX_W'(1)) begin
            op_req <= 1'b0;
            done   <= 1'b1;
            result <= disc;
            st     <= S_IDLE;
          end else begin
            idx     <= idx - 1'b1;
            op_kind <= OP_BIT;
            op_data <= 8'h01;
            st      <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    op_req && !op_done |=> op_req && $stable(op_kind) && $stable(op_data));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_result_code_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (result <= 8'(ID_W)) || result == ERR_DATA || result == ERR_PRESENCE);
  p_no_write_after_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RDC) && op_done && rd_q && op_rbit |=> !op_req && !busy);
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> idx >= IDX_W'(1) && idx <= IDX_W'(ID_W));
  p_disc_above_idx_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD || st == S_RDC) && disc != LAST_DEVICE |-> disc > 8'(idx));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(prev_q));
endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      prev_disc,
  input  logic            id_load,
  input  logic [ID_W-1:0] id_in,
  output logic            busy,
  output logic            done,
  output logic [7:0]      result,
  output logic [ID_W-1:0] id_out,
  output logic            op_req,
  output logic [1:0]      op_kind,
  output logic [7:0]      op_data,
  input  logic            op_done,
  input  logic            op_rbit
);
  localparam int IDX_W = $clog2(ID_W + 1);
  localparam int POS_W = $clog2(ID_W);

  logic             id_wr;
  logic [POS_W-1:0] id_pos;
  logic             id_bit;
  logic             load_en;

  assign load_en = id_load && !busy;

  ow_srch_seq #(.ID_W(ID_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .prev_disc(prev_disc),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .op_req   (op_req),
    .op_kind  (op_kind),
    .op_data  (op_data),
    .op_done  (op_done),
    .op_rbit  (op_rbit),
    .old_bit  (id_out[id_pos]),
    .id_wr    (id_wr),
    .id_pos   (id_pos),
    .id_bit   (id_bit)
  );

  ow_srch_idreg #(.ID_W(ID_W), .POS_W(POS_W)) u_idreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load_en),
    .load_val(id_in),
    .wr      (id_wr),
    .wr_pos  (id_pos),
    .wr_bit  (id_bit),
    .q       (id_out)
  );
endmodule

// File: tb/test_ow_rom_search.sv
`timescale 1ns/1ps
module test_ow_rom_search;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  prev_disc = '0;
  logic        id_load = 1'b0;
  logic [63:0] id_in = '0;
  logic        busy, done;
  logic [7:0]  result;
  logic [63:0] id_out;
  logic        op_req;
  logic [1:0]  op_kind;
  logic [7:0]  op_data;
  logic        op_done = 1'b0;
  logic        op_rbit = 1'b0;

  ow_rom_search i_ow_rom_search (.*);

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [63:0] dev [8];
  int          ndev = 0;
  logic [7:0]  act;
  int          epos, ephase;
  int          fault_pos = -1;
  int          n_rst, n_byte, n_bit;
  logic [7:0]  last_cmd;

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic wand_bit(input logic [7:0] m, input int p, input bit inv);
    logic r = 1'b1;
    for (int i = 0; i < ndev; i++)
      if (m[i] && ((dev[i][p] ^ inv) == 1'b0)) r = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] all_mask();
    logic [7:0] m = '0;
    for (int i = 0; i < ndev; i++) m[i] = 1'b1;
    return m;
  endfunction

  // slot engine: wired-AND model of the device set
  initial begin
    forever begin
      if (!op_req) @(negedge clk);
      else begin
        logic [1:0] k;
        logic [7:0] d;
        logic rb;
        k = op_kind;
        d = op_data;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rb = 1'b1;
        case (k)
          2'd0: begin n_rst++; act = all_mask(); epos = 0; ephase = 0; rb = (ndev > 0); end
          2'd2: begin n_byte++; last_cmd = d; end
          default: begin
            n_bit++;
            if (ephase == 0) begin
              rb = wand_bit(act, epos, 1'b0);
              if (epos == fault_pos) rb = 1'b1;
              ephase = 1;
            end else if (ephase == 1) begin
              rb = wand_bit(act, epos, 1'b1);
              if (epos == fault_pos) rb = 1'b1;
              ephase = 2;
            end else begin
              for (int i = 0; i < ndev; i++) if (dev[i][epos] != d[0]) act[i] = 1'b0;
              rb = d[0];
              epos++;
              ephase = 0;
            end
          end
        endcase
        op_rbit = rb;
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
      end
    end
  end

  task automatic ref_pass(input logic [7:0] prev, input logic [63:0] pid,
                          output logic [63:0] rid, output logic [7:0] rres);
    logic [7:0] m = all_mask();
    rid = pid;
    rres = 8'h00;
    if (ndev == 0) begin rres = 8'hFF; return; end
    for (int k = 0; k < 64; k++) begin
      int idx = 64 - k;
      logic b, cb, dr;
      b  = wand_bit(m, k, 1'b0);
      cb = wand_bit(m, k, 1'b1);
      if (b && cb) begin rres = 8'hFE; return; end
      if (!b && !cb) begin
        dr = (int'(prev) > idx) || (pid[k] && int'(prev) != idx);
        if (dr) rres = 8'(idx);
      end else dr = b;
      rid[k] = dr;
      for (int i = 0; i < ndev; i++) if (dev[i][k] != dr) m[i] = 1'b0;
    end
  endtask

  task automatic run_pass(input logic [7:0] prev, input logic [63:0] pid, input bit poke,
                          output logic [63:0] oid, output logic [7:0] ores);
    int cyc = 0;
    @(negedge clk);
    id_in = pid; id_load = 1'b1;
    @(negedge clk);
    id_load = 1'b0;
    chk(id_out == pid, "R8 id load", id_out, pid);
    n_rst = 0; n_byte = 0; n_bit = 0; last_cmd = '0;
    prev_disc = prev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) begin
      if (poke && cyc == 40) begin prev_disc = ~prev; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    oid = id_out; ores = result;
    chk(done, "R9 done seen", done, 1);
    @(negedge clk);
    chk(!done && result == ores, "R9 done pulse/result held", {done, result}, {1'b0, ores});
  endtask

  task automatic enumerate(input bit poke);
    logic [63:0] pid, rid, oid;
    logic [7:0]  prev, rres, ores;
    logic [7:0]  found = '0;
    int passes = 0;
    prev = 8'hFF;
    pid = {$urandom, $urandom};
    do begin
      ref_pass(prev, pid, rid, rres);
      run_pass(prev, pid, poke && passes == 0, oid, ores);
      passes++;
      chk(oid == rid, "R5/R7 id", oid, rid);
      chk(ores == rres, "R6 discrepancy", ores, rres);
      chk(n_rst == 1 && n_byte == 1 && n_bit == 192 && last_cmd == 8'hF0,
          "R2 op sequence", {n_rst[7:0], n_byte[7:0], n_bit[15:0], last_cmd},
          {8'd1, 8'd1, 16'd192, 8'hF0});
      for (int i = 0; i < ndev; i++) if (dev[i] == oid) found[i] = 1'b1;
      prev = ores; pid = oid;
    end while (ores != 8'h00 && passes <= ndev);
    chk(found == all_mask() && passes == ndev, "R4/R5 all devices found",
        {found, 8'(passes)}, {all_mask(), 8'(ndev)});
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] oid;
    logic [7:0]  ores;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !op_req && id_out == 0, "R9 reset state",
        {busy, done, op_req}, 0);

    // R1: nobody present
    ndev = 0;
    run_pass(8'hFF, 64'h0, 1'b0, oid, ores);
    chk(ores == 8'hFF && n_rst == 1 && n_byte == 0 && n_bit == 0, "R1 presence error",
        {ores, n_byte[7:0], n_bit[7:0]}, {8'hFF, 16'h0});

    // R3: forced 11 at position 10
    ndev = 2; dev[0] = 64'h0123_4567_89AB_CDEF; dev[1] = 64'hFEDC_BA98_7654_3210;
    fault_pos = 10;
    run_pass(8'hFF, 64'h0, 1'b0, oid, ores);
    chk(ores == 8'hFE && n_bit == 32, "R3 data error, no write", {ores, n_bit[7:0]}, {8'hFE, 8'd32});
    fault_pos = -1;

    // R4/R6: single device, no conflict
    ndev = 1; dev[0] = 64'hA5A5_0F0F_3C3C_9669;
    run_pass(8'hFF, 64'h0, 1'b0, oid, ores);
    chk(oid == dev[0] && ores == 8'h00, "R4 single device", {oid}, {dev[0]});

    // R5/R6: conflict only at index 1 (bit 63)
    ndev = 2; dev[0] = 64'h0; dev[1] = 64'h8000_0000_0000_0000;
    run_pass(8'hFF, 64'h0, 1'b0, oid, ores);
    chk(oid == dev[1] && ores == 8'd1, "R5 index-1 first pass", {oid}, {dev[1]});
    run_pass(ores, oid, 1'b0, oid, ores);
    chk(oid == dev[0] && ores == 8'd0, "R5 index-1 second pass", {oid}, {dev[0]});

    // R5/R7: conflict only at index 64 (bit 0)
    dev[0] = 64'h0; dev[1] = 64'h1;
    run_pass(8'hFF, 64'h0, 1'b0, oid, ores);
    chk(oid == 64'h1 && ores == 8'd64, "R7 index-64 first pass", {oid}, 64'h1);

    // random device sets with shared prefixes; first set pokes start mid-pass (R9)
    for (int t = 0; t < 6; t++) begin
      logic [63:0] base = {$urandom, $urandom};
      ndev = 1 + ($urandom % 8);
      for (int i = 0; i < ndev; i++) begin
        bit dup;
        do begin
          dev[i] = (i == 0) ? base
                 : base ^ (64'h1 << ($urandom % 64)) ^ (64'h1 << ($urandom % 64));
          dup = 1'b0;
          for (int j = 0; j < i; j++) if (dev[j] == dev[i]) dup = 1'b1;
        end while (dup);
      end
      enumerate(t == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule